// File: doc/BRIEF.md
# Match and Capture Timer

A free-running 32-bit up-counter with four compare channels and four capture channels, configured and observed through a flat register file. Software writes the control word to start, stop or hold the counter at zero. Each compare channel watches for the counter to equal its programmed value. On a hit it can raise a status flag, restart the counter from zero, or halt it, in any combination.

Each capture channel takes an asynchronous input pin and passes it through a synchronizer. It then looks for rising and/or falling transitions and, on a selected transition, latches the counter into its capture register, optionally raising a flag. All eight flags share one status word. Software clears a flag by writing one to its bit. A single interrupt line is active while any flag is set.

Top module: `match_capture_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. Register addresses: 0 control, 1 status, 2 counter (read only), 3 compare configuration, 4 capture configuration, 8+n compare value n, 12+n capture value n (read only).
- R2: With control bit 0 (run) set and control bit 1 (hold) clear, the counter increases by one on every clock. With the run bit clear it keeps its value.
- R3: While running, if the counter equals compare value n and compare-configuration bit 3n is set, status bit n is set at that clock edge.
- R4: While running, if the counter equals compare value n and compare-configuration bit 3n+1 is set, the counter becomes 0 on the next clock instead of incrementing.
- R5: While control bit 1 is set, the counter is held at 0 and no compare is evaluated.
- R6: While running, if the counter equals compare value n and compare-configuration bit 3n+2 is set, the run bit is cleared by hardware and the counter stops until software sets the run bit again.
- R7: When compare hits occur together, restart-to-zero wins over incrementing and halting wins over continued counting. A halt without a restart leaves the counter at the matching value. A halt together with a restart leaves it at 0.
- R8: A compare flag sets only if its interrupt bit (3n) is enabled. A capture flag sets only if its interrupt bit (3n+2) is enabled. A hit or capture with the bit clear leaves the status word unchanged.
- R9: `irq` is high exactly when at least one status bit is set.
- R10: Writing the status word clears every flag whose data bit is 1. Bits written as 0 keep their flags.
- R11: Capture channel n loads the counter into capture value n on a rising edge of `cap_in[n]` if capture-configuration bit 3n is set, and on a falling edge if bit 3n+1 is set. With both bits set, either edge captures. When the load happens and bit 3n+2 is set, status bit 4+n sets.
- R12: A capture channel with neither edge bit set never changes its capture register, whatever its pin does.
- R13: A level change on `cap_in[n]` loads the capture register and flag at the third rising clock edge after the change. The loaded value is the counter value held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| cap_in | input | 4 | Asynchronous capture pins, one per channel |
| irq | output | 1 | Interrupt, high while any status flag is set |

## Verification
A register write lands on the clock edge that samples `wr_en`. The run bit takes effect one edge later, so after a start written at edge W the counter reads j just after edge W+j. A compare hit seen while the counter holds value M acts on the following edge, and its flag, restart or halt is visible just after that edge. A capture lands on the third edge after its pin changes. The bench counts edges from each write, samples 2 ns after an edge through the combinational read port, and pushes the expected values for that exact cycle into a queue. The monitor pops them while the state is still stable. For latency, it checks that a capture flag is absent after two edges and present after three.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Per-channel compare configuration, 3 bits, interrupt enable in the LSB.
    typedef struct packed {
        logic halt;
        logic restart;
        logic irq_en;
    } cmp_cfg_t;

    // Per-channel capture configuration, 3 bits, rising select in the LSB.
    typedef struct packed {
        logic irq_en;
        logic on_fall;
        logic on_rise;
    } cap_cfg_t;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 4'd0,
        REG_STAT  = 4'd1,
        REG_COUNT = 4'd2,
        REG_CMPC  = 4'd3,
        REG_CAPC  = 4'd4
    } reg_addr_e;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_HOLD = 1;

    function automatic logic [ADDR_W-1:0] cmp_val_addr(input int idx);
        return ADDR_W'(8 + idx);
    endfunction

    function automatic logic [ADDR_W-1:0] cap_val_addr(input int idx);
        return ADDR_W'(12 + idx);
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ctrl_wr,
    input  logic                            ctrl_run_d,
    input  logic                            ctrl_hold_d,
    input  logic [N_MATCH-1:0][CNT_W-1:0]   cmp_val,
    input  cmp_cfg_t [N_MATCH-1:0]          cmp_cfg,
    output logic [CNT_W-1:0]                count_q,
    output logic                            run_q,
    output logic                            hold_q,
    output logic [N_MATCH-1:0]              cmp_flag_set
);

    logic [N_MATCH-1:0] hit, want_restart, want_halt;
    logic               restart_any, halt_any, active;
    logic [CNT_W-1:0]   count_d;
    logic               run_d, hold_d;

    assign active = run_q && !hold_q;

    for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
        assign hit[i]          = active && (count_q == cmp_val[i]);
        assign want_restart[i] = hit[i] && cmp_cfg[i].restart;
        assign want_halt[i]    = hit[i] && cmp_cfg[i].halt;
        assign cmp_flag_set[i] = hit[i] && cmp_cfg[i].irq_en;
    end

    assign restart_any = |want_restart;
    assign halt_any    = |want_halt;

    always_comb begin
        count_d = count_q;
        if (hold_q) begin
            count_d = '0;
        end else if (run_q) begin
            if (restart_any)   count_d = '0;
            else if (halt_any) count_d = count_q;
            else               count_d = count_q + 1'b1;
        end
    end

    always_comb begin
        run_d  = ctrl_wr ? ctrl_run_d  : run_q;
        hold_d = ctrl_wr ? ctrl_hold_d : hold_q;
        if (halt_any) run_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            run_q   <= 1'b0;
            hold_q  <= 1'b0;
        end else begin
            count_q <= count_d;
            run_q   <= run_d;
            hold_q  <= hold_d;
        end
    end

    p_hold_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !hold_q) |=> (count_q == $past(count_q)));

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (active && restart_any) |=> (count_q == '0));

    p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
        hold_q |=> (count_q == '0));

    p_halt_clears_run_r6: assert property (@(posedge clk) disable iff (rst)
        halt_any |=> !run_q);

    p_halt_keeps_value_r7: assert property (@(posedge clk) disable iff (rst)
        (halt_any && !restart_any) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin,
    input  cap_cfg_t          cfg,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cap_q,
    output logic              flag_set
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q, rise, fall, fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise     = sync_q[SYNC_STAGES-1] && !prev_q;
    assign fall     = !sync_q[SYNC_STAGES-1] && prev_q;
    assign fire     = (rise && cfg.on_rise) || (fall && cfg.on_fall);
    assign flag_set = fire && cfg.irq_en;

    always_ff @(posedge clk) begin
        if (rst)       cap_q <= '0;
        else if (fire) cap_q <= count;
    end

    p_quiet_keeps_r12: assert property (@(posedge clk) disable iff (rst)
        (!cfg.on_rise && !cfg.on_fall) |=> (cap_q == $past(cap_q)));

    p_load_on_fire_r11: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cap_q == $past(count)));

endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_in,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] flags_q,
    output logic         irq
);

    logic [W-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_eff) | set_in;
    end

    assign irq = |flags_q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        p_w1c_clears_r10: assert property (@(posedge clk) disable iff (rst)
            (clr_wr && clr_mask[i] && !set_in[i]) |=> !flags_q[i]);
        p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
            (flags_q[i] && !(clr_wr && clr_mask[i])) |=> flags_q[i]);
        p_set_lands_r3: assert property (@(posedge clk) disable iff (rst)
            set_in[i] |=> flags_q[i]);
    end

endmodule

// File: rtl/match_capture_timer.sv
module match_capture_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int N_MATCH     = 4,
    parameter int N_CAP       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [3:0]        rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [N_CAP-1:0]  cap_in,
    output logic              irq
);

    localparam int ST_W   = N_MATCH + N_CAP;
    localparam int CMPC_W = 3 * N_MATCH;
    localparam int CAPC_W = 3 * N_CAP;

    logic [N_MATCH-1:0][CNT_W-1:0] cmp_val_q;
    cmp_cfg_t [N_MATCH-1:0]        cmp_cfg_q;
    cap_cfg_t [N_CAP-1:0]          cap_cfg_q;
    logic [N_CAP-1:0][CNT_W-1:0]   cap_val;
    logic [N_CAP-1:0]              cap_set;
    logic [N_MATCH-1:0]            cmp_set;
    logic [CNT_W-1:0]              count;
    logic                          run_q, hold_q;
    logic [ST_W-1:0]               flags;
    logic                          ctrl_wr, stat_wr;

    assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
    assign stat_wr = wr_en && (wr_addr == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_cfg_q <= '0;
            cap_cfg_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_CMPC) cmp_cfg_q <= wr_data[CMPC_W-1:0];
            if (wr_addr == REG_CAPC) cap_cfg_q <= wr_data[CAPC_W-1:0];
        end
    end

    for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp_reg
        always_ff @(posedge clk) begin
            if (rst)
                cmp_val_q[i] <= '0;
            else if (wr_en && wr_addr == cmp_val_addr(i))
                cmp_val_q[i] <= wr_data;
        end
    end

    tmr_counter #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_counter (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr      (ctrl_wr),
        .ctrl_run_d   (wr_data[CTRL_RUN]),
        .ctrl_hold_d  (wr_data[CTRL_HOLD]),
        .cmp_val      (cmp_val_q),
        .cmp_cfg      (cmp_cfg_q),
        .count_q      (count),
        .run_q        (run_q),
        .hold_q       (hold_q),
        .cmp_flag_set (cmp_set)
    );

    for (genvar i = 0; i < N_CAP; i++) begin : g_cap
        tmr_capture_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
            .clk      (clk),
            .rst      (rst),
            .pin      (cap_in[i]),
            .cfg      (cap_cfg_q[i]),
            .count    (count),
            .cap_q    (cap_val[i]),
            .flag_set (cap_set[i])
        );
    end

    tmr_status #(.W(ST_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_in   ({cap_set, cmp_set}),
        .clr_wr   (stat_wr),
        .clr_mask (wr_data[ST_W-1:0]),
        .flags_q  (flags),
        .irq      (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CTRL:  begin
                rd_data[CTRL_RUN]  = run_q;
                rd_data[CTRL_HOLD] = hold_q;
            end
            REG_STAT:  rd_data[ST_W-1:0]   = flags;
            REG_COUNT: rd_data             = count;
            REG_CMPC:  rd_data[CMPC_W-1:0] = cmp_cfg_q;
            REG_CAPC:  rd_data[CAPC_W-1:0] = cap_cfg_q;
            default: begin
                for (int i = 0; i < N_MATCH; i++)
                    if (rd_addr == cmp_val_addr(i)) rd_data = cmp_val_q[i];
                for (int i = 0; i < N_CAP; i++)
                    if (rd_addr == cap_val_addr(i)) rd_data = cap_val[i];
            end
        endcase
    end

    p_irq_tracks_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && (wr_data[ST_W-1:0] == {ST_W{1'b1}}) && !(|{cap_set, cmp_set}))
        |=> !irq);

endmodule

// File: tb/test_match_capture_timer.sv
module test_match_capture_timer;

    localparam int A_CTRL = 0, A_STAT = 1, A_CNT = 2, A_CMPC = 3, A_CAPC = 4;
    localparam int A_CMP0 = 8, A_CAP0 = 12;
    localparam int SEL_IRQ = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  cap_in = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  ev_push;

    always #10 clk = ~clk;

    match_capture_timer i_match_capture_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .irq(irq)
    );

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            @(ev_push);
            #2;
            while (q.size() != 0) begin
                it  = q.pop_front();
                act = (it.sel == SEL_IRQ) ? {31'b0, irq} : rd_data;
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic chk(input int sel, input logic [31:0] exp, input string tag);
        item_t it;
        if (sel != SEL_IRQ) rd_addr = sel[3:0];
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
        -> ev_push;
        #4;
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr[3:0]; wr_data = data;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(A_CTRL, 0, "R1 ctrl");
        chk(A_STAT, 0, "R1 status");
        chk(A_CNT, 0, "R1 count");
        chk(SEL_IRQ, 0, "R1 irq");

        // R2/R3/R4: compare 0 at 5 with flag and restart
        wr(A_CMP0, 5);
        wr(A_CMPC, 32'h003);
        wr(A_CTRL, 1);
        tick(3);
        chk(A_CNT, 3, "R2 counting");
        tick(3);
        chk(A_CNT, 0, "R4 restart");
        chk(A_STAT, 32'h01, "R3 match flag");
        chk(SEL_IRQ, 1, "R9 irq high");
        tick(2);
        chk(A_CNT, 2, "R4 after restart");

        // R2 hold while stopped, R10 write-one-to-clear
        wr(A_CTRL, 0);
        tick(4);
        chk(A_CNT, 3, "R2 stopped holds");
        wr(A_STAT, 32'h02);
        chk(A_STAT, 32'h01, "R10 zero bit keeps flag");
        chk(SEL_IRQ, 1, "R9 irq still high");
        wr(A_STAT, 32'h01);
        chk(A_STAT, 0, "R10 cleared");
        chk(SEL_IRQ, 0, "R9 irq low");

        // R5 hold bit
        wr(A_CTRL, 3);
        tick(3);
        chk(A_CNT, 0, "R5 held at zero");
        chk(A_CTRL, 3, "R5 ctrl readback");
        wr(A_CTRL, 1);
        tick(4);
        chk(A_CNT, 4, "R5 release");

        // R6/R8: compare 1 at 7 with flag and halt, compare 0 flag off
        wr(A_CTRL, 0);
        wr(A_STAT, 32'hFF);
        wr(A_CMPC, 32'h028);
        wr(A_CMP0 + 1, 7);
        wr(A_CTRL, 2);
        wr(A_CTRL, 1);
        tick(10);
        chk(A_CNT, 7, "R6 halted at match");
        chk(A_CTRL, 0, "R6 run bit cleared");
        chk(A_STAT, 32'h02, "R8 only enabled flag");
        chk(SEL_IRQ, 1, "R9 irq");

        // R7: restart and halt together at 4, no flags enabled
        wr(A_STAT, 32'hFF);
        wr(A_CMPC, 32'h880);
        wr(A_CMP0 + 2, 4);
        wr(A_CMP0 + 3, 4);
        wr(A_CTRL, 2);
        wr(A_CTRL, 1);
        tick(8);
        chk(A_CNT, 0, "R7 restart wins");
        chk(A_CTRL, 0, "R7 halted");
        chk(A_STAT, 0, "R8 no flag without enable");

        // R11/R12 capture: ch0 rise+irq, ch1 fall, ch2 both+irq, ch3 none
        wr(A_CMPC, 0);
        wr(A_CAPC, 32'h1D5);
        wr(A_CTRL, 2);
        wr(A_CTRL, 1);
        tick(9);
        wr(A_CTRL, 0);
        cap_in = 4'hF;
        tick(3);
        chk(A_CAP0 + 0, 10, "R11 rise capture ch0");
        chk(A_CAP0 + 1, 0, "R11 fall-only ignores rise");
        chk(A_CAP0 + 2, 10, "R11 both edges rise");
        chk(A_CAP0 + 3, 0, "R12 no edge select");
        tick(1);
        chk(A_STAT, 32'h50, "R11 capture flags");
        chk(SEL_IRQ, 1, "R9 irq capture");

        wr(A_CTRL, 1);
        tick(4);
        wr(A_CTRL, 0);
        wr(A_STAT, 32'hFF);
        cap_in = 4'h0;
        tick(3);
        chk(A_CAP0 + 0, 10, "R11 rise-only ignores fall");
        chk(A_CAP0 + 1, 15, "R11 fall capture ch1");
        chk(A_CAP0 + 2, 15, "R11 both edges fall");
        chk(A_CAP0 + 3, 0, "R12 still untouched");
        tick(1);
        chk(A_STAT, 32'h40, "R8 ch1 no flag");

        // R13 latency with running counter
        wr(A_STAT, 32'hFF);
        wr(A_CTRL, 1);
        cap_in = 4'h1;
        tick(2);
        chk(A_STAT, 0, "R13 not yet after two edges");
        tick(1);
        chk(A_STAT, 32'h10, "R13 flag on third edge");
        chk(A_CAP0 + 0, 17, "R13 value before edge");
        chk(A_CNT, 18, "R2 counter running");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule